// File: doc/BRIEF.md
# Interrupt acceptance and stacking sequencer

This block decides when a pending interrupt may begin exception handling in a small processor whose bus is shared with a data transfer engine. Requests come from a set of maskable lines, each with a fixed priority level, and from one non-maskable line. The non-maskable line is captured on its rising edge and held until it is serviced. Acceptance happens only at an instruction boundary. A transfer cycle closes that window for every source, the non-maskable one included. The window stays closed until one more instruction has completed after the transfer ends.

When a request is accepted, the block pushes an exception frame onto the stack. It writes one byte per clock and moves the stack pointer down by one for each byte. The saved program counter is the address of the next instruction. The frame is 4 bytes in the small address mode. In the large mode it is 6 bytes, with a code-page byte and one padding byte added. The frame must start on an even stack address. If the pointer presented at acceptance is odd, the block raises an alignment error and writes nothing. After the last byte it pulses a start strobe together with the vector index of the accepted source.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, `stk_we`, `handler_go`, `align_err` and `handler_vec` are 0, and `sp_out` is 0.
- R2: A request can be accepted only in a cycle where `insn_done` is 1, `xfer_active` is 0 and no frame is in progress. A boundary strobe seen while `xfer_active` is 1 accepts nothing.
- R3: After `xfer_active` falls, the first `insn_done` is not an acceptance point. The earliest acceptance is at the following `insn_done`.
- R4: The hold-off of R2 and R3 applies to the non-maskable request exactly as it does to maskable requests.
- R5: When a latched non-maskable request and an eligible maskable request are both present at acceptance, the non-maskable one is taken, with vector index 0.
- R6: Maskable line i has level i+1. It is eligible only when that level is strictly greater than the mask field `sr_in[MASK_LSB +: LVL_W]`. Among eligible lines the highest index wins, with vector index i+1. With no eligible source, a boundary accepts nothing.
- R7: In small mode (`max_mode`=0) the frame is 4 bytes, written one per cycle starting the cycle after the acceptance edge. The bytes go to addresses sp-1, sp-2, sp-3, sp-4 and hold PC low, PC high, SR low and SR high, in that order.
- R8: In large mode (`max_mode`=1) the frame is 6 bytes at sp-1 down to sp-6. They hold PC low, PC high, page, 0x00 padding, SR low and SR high, in that order.
- R9: During a push, `stk_addr` equals `sp_out` on every write, and `sp_out` drops by one per byte. It ends at sp minus the frame length.
- R10: `handler_go` is 1 for exactly one cycle, the cycle after the last byte is written. `handler_vec` holds the accepted vector index in that cycle.
- R11: Requests and boundary strobes that arrive during a push do not change the frame being written. A non-maskable rising edge seen then stays latched and is accepted at a later boundary.
- R12: If `sp_in` is odd at acceptance, `align_err` pulses for one cycle. No byte is written, no `handler_go` is raised, and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_IRQ | Maskable request lines, level-sensitive |
| nmi_in | input | 1 | Non-maskable request, captured on rising edge |
| xfer_active | input | 1 | Data transfer cycle in progress |
| insn_done | input | 1 | One-cycle instruction boundary strobe |
| max_mode | input | 1 | 1 selects the 6-byte frame with page byte |
| pc_next | input | 2*BYTE_W | Address of the next instruction |
| sr_in | input | 2*BYTE_W | Status register, holds the mask field |
| page_in | input | BYTE_W | Code page register |
| sp_in | input | ADDR_W | Current stack pointer |
| stk_we | output | 1 | Stack byte write enable |
| stk_addr | output | ADDR_W | Stack byte address |
| stk_data | output | BYTE_W | Stack byte data |
| sp_out | output | ADDR_W | Updated stack pointer |
| handler_go | output | 1 | One-cycle start-of-handler strobe |
| handler_vec | output | VEC_W | Vector index of the accepted source |
| align_err | output | 1 | One-cycle pulse on an odd stack pointer |

## Verification
The bench builds the block with its default parameters: four maskable lines at levels 1 to 4, a 3-bit mask, byte-wide data and a 16-bit stack pointer. Because the mask runs from 0 to 7, the bench can set it so that all lines are eligible, some are, or none are, and can check the strict greater-than comparison at its edge. The `max_mode` input switches between both frame layouts on the same build, so both byte orders and both end pointers are checked. The transfer hold-off is driven with the non-maskable source, which is the case where a designer would most likely bypass the gate.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_PUSH = 2'd1,
    PS_DONE = 2'd2
  } push_state_e;

  localparam int FRAME_MAX_BYTES = 6;
  localparam int FRAME_MIN_BYTES = 4;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 4,
  parameter int LVL_W   = 3,
  parameter int VEC_W   = 3
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [LVL_W-1:0]   mask,
  input  logic               nmi_pend,
  output logic               hit,
  output logic               nmi_sel,
  output logic [VEC_W-1:0]   vec
);
  logic [NUM_IRQ-1:0] elig;

  // each line carries a fixed level one above its index
  for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_line
    localparam logic [LVL_W-1:0] LINE_LVL = LVL_W'(gi + 1);
    assign elig[gi] = irq_req[gi] && (LINE_LVL > mask);
  end

  always_comb begin
    hit     = nmi_pend | (|elig);
    nmi_sel = nmi_pend;
    vec     = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (elig[i]) vec = VEC_W'(i + 1);
    end
    if (nmi_pend) vec = '0;
  end
endmodule

// File: rtl/xfer_gate.sv
module xfer_gate (
  input  logic clk,
  input  logic rst,
  input  logic xfer_active,
  input  logic insn_done,
  output logic boundary_ok
);
  logic hold_q;

  // hold is armed by any transfer cycle and released by the first
  // completed instruction once the transfer has ended
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
    end else if (xfer_active) begin
      hold_q <= 1'b1;
    end else if (insn_done) begin
      hold_q <= 1'b0;
    end
  end

  assign boundary_ok = insn_done && !xfer_active && !hold_q;

  p_hold_after_xfer_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_active) |-> hold_q);

  p_release_needs_insn_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_q)) |-> $past(insn_done) && !$past(xfer_active));
endmodule

// File: rtl/frame_pusher.sv
module frame_pusher
  import irq_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16,
  parameter int VEC_W  = 3,
  parameter int MAXB   = FRAME_MAX_BYTES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [MAXB-1:0][BYTE_W-1:0]  frame_in,
  input  logic [$clog2(MAXB+1)-1:0]    len_in,
  input  logic [ADDR_W-1:0]            sp_base,
  input  logic [VEC_W-1:0]             vec_in,
  output logic                         busy,
  output logic                         stk_we,
  output logic [ADDR_W-1:0]            stk_addr,
  output logic [BYTE_W-1:0]            stk_data,
  output logic [ADDR_W-1:0]            sp_out,
  output logic                         go,
  output logic [VEC_W-1:0]             vec_out
);
  localparam int LEN_W = $clog2(MAXB + 1);

  push_state_e                 st;
  logic [MAXB-1:0][BYTE_W-1:0] frm_q;
  logic [LEN_W-1:0]            left_q;
  logic [ADDR_W-1:0]           sp_q;
  logic [VEC_W-1:0]            vec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_IDLE;
      frm_q    <= '0;
      left_q   <= '0;
      sp_q     <= '0;
      vec_q    <= '0;
      stk_we   <= 1'b0;
      stk_addr <= '0;
      stk_data <= '0;
      go       <= 1'b0;
      vec_out  <= '0;
    end else begin
      stk_we <= 1'b0;
      go     <= 1'b0;
      case (st)
        PS_IDLE: begin
          if (start) begin
            frm_q  <= frame_in;
            left_q <= len_in;
            sp_q   <= sp_base;
            vec_q  <= vec_in;
            st     <= PS_PUSH;
          end
        end
        PS_PUSH: begin
          stk_we   <= 1'b1;
          stk_data <= frm_q[0];
          stk_addr <= sp_q - 1'b1;
          sp_q     <= sp_q - 1'b1;
          for (int k = 0; k < MAXB - 1; k++) frm_q[k] <= frm_q[k+1];
          frm_q[MAXB-1] <= '0;
          left_q <= left_q - 1'b1;
          if (left_q == LEN_W'(1)) st <= PS_DONE;
        end
        PS_DONE: begin
          go      <= 1'b1;
          vec_out <= vec_q;
          st      <= PS_IDLE;
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign busy   = (st != PS_IDLE);
  assign sp_out = sp_q;

  p_addr_is_sp_r9: assert property (@(posedge clk) disable iff (rst)
    stk_we |-> stk_addr == sp_out);

  p_sp_step_r9: assert property (@(posedge clk) disable iff (rst)
    (stk_we && $past(stk_we)) |-> sp_out == $past(sp_out) - 1'b1);

  p_go_single_r10: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

  p_go_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    go |-> $past(stk_we) && !stk_we);

  p_even_base_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_we) |-> stk_addr[0]);
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int LVL_W    = 3,
  parameter int BYTE_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int MASK_LSB = 8,
  parameter int VEC_W    = $clog2(NUM_IRQ + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_IRQ-1:0]    irq_req,
  input  logic                  nmi_in,
  input  logic                  xfer_active,
  input  logic                  insn_done,
  input  logic                  max_mode,
  input  logic [2*BYTE_W-1:0]   pc_next,
  input  logic [2*BYTE_W-1:0]   sr_in,
  input  logic [BYTE_W-1:0]     page_in,
  input  logic [ADDR_W-1:0]     sp_in,
  output logic                  stk_we,
  output logic [ADDR_W-1:0]     stk_addr,
  output logic [BYTE_W-1:0]     stk_data,
  output logic [ADDR_W-1:0]     sp_out,
  output logic                  handler_go,
  output logic [VEC_W-1:0]      handler_vec,
  output logic                  align_err
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int MAXB   = FRAME_MAX_BYTES;
  localparam int LEN_W  = $clog2(MAXB + 1);

  logic nmi_q, nmi_pend;
  logic boundary_ok;
  logic hit, nmi_sel;
  logic [VEC_W-1:0] sel_vec;
  logic busy, accept, start;
  logic [MAXB-1:0][BYTE_W-1:0] frame;
  logic [LEN_W-1:0] frame_len;

  xfer_gate u_gate (
    .clk         (clk),
    .rst         (rst),
    .xfer_active (xfer_active),
    .insn_done   (insn_done),
    .boundary_ok (boundary_ok)
  );

  irq_arbiter #(.NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_arb (
    .irq_req  (irq_req),
    .mask     (sr_in[MASK_LSB +: LVL_W]),
    .nmi_pend (nmi_pend),
    .hit      (hit),
    .nmi_sel  (nmi_sel),
    .vec      (sel_vec)
  );

  assign accept = boundary_ok && hit && !busy;
  assign start  = accept && !sp_in[0];

  // non-maskable edge latch; a new edge wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi_in;
      if (nmi_in && !nmi_q) nmi_pend <= 1'b1;
      else if (start && nmi_sel) nmi_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) align_err <= 1'b0;
    else     align_err <= accept && sp_in[0];
  end

  // push order: first entry lands at sp-1
  always_comb begin
    frame    = '0;
    frame[0] = pc_next[BYTE_W-1:0];
    frame[1] = pc_next[WORD_W-1:BYTE_W];
    if (max_mode) begin
      frame[2]  = page_in;
      frame[3]  = '0;
      frame[4]  = sr_in[BYTE_W-1:0];
      frame[5]  = sr_in[WORD_W-1:BYTE_W];
      frame_len = LEN_W'(FRAME_MAX_BYTES);
    end else begin
      frame[2]  = sr_in[BYTE_W-1:0];
      frame[3]  = sr_in[WORD_W-1:BYTE_W];
      frame_len = LEN_W'(FRAME_MIN_BYTES);
    end
  end

  frame_pusher #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .MAXB(MAXB)) u_push (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frame_in (frame),
    .len_in   (frame_len),
    .sp_base  (sp_in),
    .vec_in   (sel_vec),
    .busy     (busy),
    .stk_we   (stk_we),
    .stk_addr (stk_addr),
    .stk_data (stk_data),
    .sp_out   (sp_out),
    .go       (handler_go),
    .vec_out  (handler_vec)
  );

  p_no_start_in_xfer_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> !$past(xfer_active) && $past(insn_done));

  p_nmi_first_r5: assert property (@(posedge clk) disable iff (rst)
    (start && nmi_pend) |-> sel_vec == '0);

  p_align_nowrite_r12: assert property (@(posedge clk) disable iff (rst)
    align_err |=> !stk_we && !busy);

  p_nmi_kept_r12: assert property (@(posedge clk) disable iff (rst)
    (align_err && $past(nmi_pend)) |-> nmi_pend);
endmodule

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  irq_req;
  logic        nmi_in, xfer_active, insn_done, max_mode;
  logic [15:0] pc_next, sr_in, sp_in;
  logic [7:0]  page_in;
  logic        stk_we, handler_go, align_err;
  logic [15:0] stk_addr, sp_out;
  logic [7:0]  stk_data;
  logic [2:0]  handler_vec;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stack_seq i_irq_stack_seq (
    .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_in(nmi_in),
    .xfer_active(xfer_active), .insn_done(insn_done), .max_mode(max_mode),
    .pc_next(pc_next), .sr_in(sr_in), .page_in(page_in), .sp_in(sp_in),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_data(stk_data),
    .sp_out(sp_out), .handler_go(handler_go), .handler_vec(handler_vec),
    .align_err(align_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      chk(req, "stk_we idle", stk_we, 0);
      chk(req, "go idle", handler_go, 0);
      @(negedge clk);
    end
  endtask

  // boundary strobe, then full frame, go strobe and final pointer
  task automatic expect_frame(input string req, input logic [2:0] vec,
                              input bit disturb);
    logic [7:0] exp_b[6];
    int n;
    logic [15:0] sp0 = sp_in;
    exp_b[0] = pc_next[7:0];
    exp_b[1] = pc_next[15:8];
    if (max_mode) begin
      exp_b[2] = page_in; exp_b[3] = 8'h00;
      exp_b[4] = sr_in[7:0]; exp_b[5] = sr_in[15:8]; n = 6;
    end else begin
      exp_b[2] = sr_in[7:0]; exp_b[3] = sr_in[15:8];
      exp_b[4] = 8'h00; exp_b[5] = 8'h00; n = 4;
    end
    boundary();
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, "we", stk_we, 1);
      chk(req, "addr", stk_addr, sp0 - 16'(k + 1));
      chk(req, "data", stk_data, exp_b[k]);
      chk("R9", "sp_out", sp_out, sp0 - 16'(k + 1));
      chk("R10", "go early", handler_go, 0);
      if (disturb) begin
        if (k == 0) begin nmi_in = 1'b1; irq_req = 4'hF; end
        if (k == 1) begin nmi_in = 1'b0; insn_done = 1'b1; end
        if (k == 2) insn_done = 1'b0;
      end
    end
    @(negedge clk);
    chk("R10", "go", handler_go, 1);
    chk("R10", "vec", handler_vec, vec);
    chk("R10", "we after", stk_we, 0);
    chk("R9", "final sp", sp_out, sp0 - 16'(n));
    @(negedge clk);
    chk("R10", "go single", handler_go, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "stk_we", stk_we, 0);
    chk("R1", "go", handler_go, 0);
    chk("R1", "align_err", align_err, 0);
    chk("R1", "vec", handler_vec, 0);
    chk("R1", "sp_out", sp_out, 0);
  endtask

  task automatic t_min_frame();
    max_mode = 0; sp_in = 16'h0400; pc_next = 16'h1234;
    sr_in = 16'h08C3; irq_req = 4'b0100;
    expect_frame("R7", 3'd3, 1'b0);
    irq_req = 4'b0000;
  endtask

  task automatic t_max_nmi();
    max_mode = 1; sp_in = 16'h0800; pc_next = 16'hBEEF;
    sr_in = 16'h0056; page_in = 8'h7A; irq_req = 4'b1000;
    @(negedge clk) nmi_in = 1'b1;
    @(negedge clk) nmi_in = 1'b0;
    expect_frame("R8", 3'd0, 1'b0);
    irq_req = 4'b0000;
  endtask

  task automatic t_mask();
    max_mode = 0; sp_in = 16'h0200; pc_next = 16'h0042;
    sr_in = 16'h0300; irq_req = 4'b0111;
    boundary();
    expect_quiet("R6", 3);
    irq_req = 4'b1111;
    expect_frame("R6", 3'd4, 1'b0);
    sr_in = 16'h0100; irq_req = 4'b0111;
    expect_frame("R6", 3'd3, 1'b0);
    irq_req = 4'b0000;
  endtask

  task automatic t_xfer_nmi();
    max_mode = 0; sp_in = 16'h0300; pc_next = 16'h5566;
    sr_in = 16'h0700; irq_req = 4'b0000;
    @(negedge clk) xfer_active = 1'b1; nmi_in = 1'b1;
    @(negedge clk) nmi_in = 1'b0;
    boundary();
    expect_quiet("R2", 2);
    xfer_active = 1'b0;
    @(negedge clk);
    boundary();
    expect_quiet("R3", 2);
    expect_frame("R4", 3'd0, 1'b0);
  endtask

  task automatic t_disturb();
    max_mode = 0; sp_in = 16'h0500; pc_next = 16'hA0A1;
    sr_in = 16'h00C0; irq_req = 4'b0001;
    expect_frame("R11", 3'd1, 1'b1);
    irq_req = 4'b0000;
    expect_quiet("R11", 2);
    pc_next = 16'hA0A3;
    expect_frame("R11", 3'd0, 1'b0);
  endtask

  task automatic t_odd_sp();
    max_mode = 1; sp_in = 16'h0401; pc_next = 16'h0C0D;
    sr_in = 16'h0000; page_in = 8'h11; irq_req = 4'b0010;
    boundary();
    chk("R12", "align_err", align_err, 1);
    chk("R12", "we", stk_we, 0);
    @(negedge clk);
    chk("R12", "align_err single", align_err, 0);
    expect_quiet("R12", 6);
    sp_in = 16'h0402;
    expect_frame("R12", 3'd2, 1'b0);
    irq_req = 4'b0000;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_req = '0; nmi_in = 0; xfer_active = 0; insn_done = 0;
    max_mode = 0; pc_next = '0; sr_in = '0; page_in = '0; sp_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_min_frame();
    t_max_nmi();
    t_mask();
    t_xfer_nmi();
    t_disturb();
    t_odd_sp();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule